// File: doc/BRIEF.md
# Subscriber line state controller

This block is the digital sequencer for an analog subscriber-line interface device. It drives the device's four parallel mode pins and watches the device's active-low loop-status line. From simple host requests (a ring level, a metering pulse, a polarity-flip pulse and a power-down level) it chooses among power-down, high-impedance idle, active feed, metering injection and ringing. Off-hook, on-hook and ring-trip reports from the line also move it between these modes.

Ringing is built in the digital domain. While a burst lasts, the polarity pin flips every half ring period. Between bursts the line sits in active on-hook feed with normal polarity. When a burst ends, whether through its timer, a ring trip or a host cancel, the polarity pin is first frozen for one tick. Only after that does the controller leave ring mode. A square-wave tone clock for the metering filter runs for exactly as long as the metering mode is on the pins.

All timing comes from a prescaled tick. The debounce time, half ring period, burst length, pause length, on-hook hang time and metering length are tick-count parameters. The tone half period is a count of system clock cycles.

Top module: `line_state_ctrl`

## Requirements
- R1: After reset the pins show idle: line_en_o=1, mode_a_o=0, mode_b_o=0, polarity_o=0, and tone_o=0.
- R2: While pwr_down_req is high, all four pins are 0 whatever state the block was in. loop_n_i, meter_req and rev_req have no effect in that mode. Releasing the request returns the block to idle.
- R3: In idle, loop_n_i held low longer than the debounce time moves the pins to active feed with line_en_o=1, mode_a_o=0, mode_b_o=1 and polarity_o=0 (normal polarity).
- R4: In active feed, a one-cycle rev_req pulse inverts polarity_o.
- R5: In active feed, a one-cycle meter_req pulse sets mode_a_o=1 and mode_b_o=1 for METER_TICKS ticks, with polarity_o kept. The pins then return to active feed.
- R6: tone_o is a square wave with a high and low time of TONE_HALF clock cycles whenever mode_a_o and mode_b_o are both 1. It is 0 at all other times.
- R7: A ring_req level in idle with the line on-hook starts a burst: mode_a_o=1, mode_b_o=0, polarity_o starting at 0 and inverting every RING_HALF ticks for RING_BURST ticks.
- R8: At the end of a burst, polarity_o is held until the next tick. The pins then show a pause (mode_a_o=0, mode_b_o=1, polarity_o=0) for RING_PAUSE ticks, followed by the next burst.
- R9: A loop-active report during a burst freezes polarity_o until the next tick. The pins then show active feed with normal polarity.
- R10: Dropping ring_req ends the cadence: the pins show idle, after the polarity hold when the request drops during a burst.
- R11: Active feed returns to idle only after loop_n_i has been high continuously for more than HANG_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_req | input | 1 | Host level: ring the line |
| meter_req | input | 1 | Host pulse: send one metering pulse |
| rev_req | input | 1 | Host pulse: invert feed polarity |
| pwr_down_req | input | 1 | Host level: power the line down |
| loop_n_i | input | 1 | Loop-status report from the line device, active low |
| line_en_o | output | 1 | 0 powers the line device down |
| mode_a_o | output | 1 | Mode select bit A |
| mode_b_o | output | 1 | Mode select bit B |
| polarity_o | output | 1 | Feed polarity, 1 = reverse; toggled for ringing |
| tone_o | output | 1 | Metering tone square wave |

## Verification
The scoreboard follows every change of the four mode pins. This makes the ring cadence visible as an exact pin-by-pin sequence: three polarity flips, a pause, the next burst, and then a cancel that must land on idle rather than on a pause. A ring trip starts while a burst is live, so the test shows whether the exit is always active normal feed. Loop-status toggles during power-down show whether the line report is truly ignored there. Releasing power-down with the loop still closed shows whether idle is passed through on the way to active feed. An on-hook release is timed against the hang window to separate a premature return to idle from a correct one. The tone is measured while the metering mode is on the pins, to confirm its half period.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [2:0] {
    S_PWRDN,
    S_IDLE,
    S_ACT,
    S_METER,
    S_BURST,
    S_HOLD,
    S_PAUSE
  } lsc_state_e;

  typedef struct packed {
    logic line_en;
    logic mode_a;
    logic mode_b;
    logic pol;
  } lsc_pins_t;

  // pin encoding for each controller state
  function automatic lsc_pins_t pins_of(lsc_state_e s, logic feed_pol, logic ring_pol);
    lsc_pins_t p;
    p = '0;
    case (s)
      S_PWRDN: p = '0;
      S_IDLE:  p.line_en = 1'b1;
      S_ACT: begin
        p.line_en = 1'b1;
        p.mode_b  = 1'b1;
        p.pol     = feed_pol;
      end
      S_METER: begin
        p.line_en = 1'b1;
        p.mode_a  = 1'b1;
        p.mode_b  = 1'b1;
        p.pol     = feed_pol;
      end
      S_BURST, S_HOLD: begin
        p.line_en = 1'b1;
        p.mode_a  = 1'b1;
        p.pol     = ring_pol;
      end
      S_PAUSE: begin
        p.line_en = 1'b1;
        p.mode_b  = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lsc_tick.sv
module lsc_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = $clog2(TICK_DIV + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(TICK_DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lsc_debounce.sv
module lsc_debounce #(
  parameter int DEB_TICKS = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic loop_n_i,
  output logic loop_o
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  logic          s1_q, s2_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      loop_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= loop_n_i;
      s2_q <= s1_q;
      if (~s2_q == loop_o) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == DW'(DEB_TICKS - 1)) begin
          loop_o <= ~s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsc_tone.sv
module lsc_tone #(
  parameter int TONE_HALF = 5208
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tone_o
);
  localparam int HW = $clog2(TONE_HALF + 1);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q  <= '0;
      tone_o <= 1'b0;
    end else if (cnt_q == HW'(TONE_HALF - 1)) begin
      cnt_q  <= '0;
      tone_o <= ~tone_o;
    end else begin
      cnt_q <= cnt_q + HW'(1);
    end
  end
endmodule

// File: rtl/lsc_fsm.sv
module lsc_fsm
  import lsc_pkg::*;
#(
  parameter int RING_HALF   = 3125,
  parameter int RING_BURST  = 250000,
  parameter int RING_PAUSE  = 500000,
  parameter int HANG_TICKS  = 25000,
  parameter int METER_TICKS = 18750
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      loop_i,
  input  logic      ring_req_i,
  input  logic      meter_req_i,
  input  logic      rev_req_i,
  input  logic      pwr_down_req_i,
  output lsc_pins_t pins_o,
  output logic      meter_next_o
);
  localparam int M1   = (RING_BURST > RING_PAUSE) ? RING_BURST : RING_PAUSE;
  localparam int M2   = (HANG_TICKS > METER_TICKS) ? HANG_TICKS : METER_TICKS;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int HW   = $clog2(RING_HALF + 1);

  lsc_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [HW-1:0] half_q, half_d;
  logic          pol_q, pol_d;
  logic          rpol_q, rpol_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    half_d  = half_q;
    pol_d   = pol_q;
    rpol_d  = rpol_q;
    case (state_q)
      S_PWRDN: if (!pwr_down_req_i) state_d = S_IDLE;
      S_IDLE: begin
        if (loop_i) begin
          state_d = S_ACT;
          pol_d   = 1'b0;
        end else if (ring_req_i) begin
          state_d = S_BURST;
          rpol_d  = 1'b0;
          half_d  = '0;
        end
      end
      S_ACT: begin
        if (meter_req_i) begin
          state_d = S_METER;
        end else begin
          if (rev_req_i) pol_d = ~pol_q;
          if (loop_i) begin
            tmr_d = '0;
          end else if (tick_i) begin
            if (tmr_q == TW'(HANG_TICKS)) state_d = S_IDLE;
            else tmr_d = tmr_q + TW'(1);
          end
        end
      end
      S_METER: begin
        if (tick_i) begin
          if (tmr_q == TW'(METER_TICKS - 1)) state_d = S_ACT;
          else tmr_d = tmr_q + TW'(1);
        end
      end
      S_BURST: begin
        if (loop_i || !ring_req_i) begin
          state_d = S_HOLD;
        end else if (tick_i) begin
          if (tmr_q == TW'(RING_BURST - 1)) begin
            state_d = S_HOLD;
          end else begin
            tmr_d = tmr_q + TW'(1);
            if (half_q == HW'(RING_HALF - 1)) begin
              half_d = '0;
              rpol_d = ~rpol_q;
            end else begin
              half_d = half_q + HW'(1);
            end
          end
        end
      end
      S_HOLD: begin
        if (tick_i) begin
          if (loop_i) begin
            state_d = S_ACT;
            pol_d   = 1'b0;
          end else if (!ring_req_i) begin
            state_d = S_IDLE;
          end else begin
            state_d = S_PAUSE;
          end
        end
      end
      S_PAUSE: begin
        if (loop_i) begin
          state_d = S_ACT;
          pol_d   = 1'b0;
        end else if (!ring_req_i) begin
          state_d = S_IDLE;
        end else if (tick_i) begin
          if (tmr_q == TW'(RING_PAUSE - 1)) begin
            state_d = S_BURST;
            rpol_d  = 1'b0;
            half_d  = '0;
          end else begin
            tmr_d = tmr_q + TW'(1);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (pwr_down_req_i) state_d = S_PWRDN;
    if (state_d != state_q) tmr_d = '0;
  end

  assign meter_next_o = (state_d == S_METER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      half_q  <= '0;
      pol_q   <= 1'b0;
      rpol_q  <= 1'b0;
      pins_o  <= pins_of(S_IDLE, 1'b0, 1'b0);
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      half_q  <= half_d;
      pol_q   <= pol_d;
      rpol_q  <= rpol_d;
      pins_o  <= pins_of(state_d, pol_d, rpol_d);
    end
  end
endmodule

// File: rtl/line_state_ctrl.sv
module line_state_ctrl
  import lsc_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int DEB_TICKS   = 1250,
  parameter int RING_HALF   = 3125,
  parameter int RING_BURST  = 250000,
  parameter int RING_PAUSE  = 500000,
  parameter int HANG_TICKS  = 25000,
  parameter int METER_TICKS = 18750,
  parameter int TONE_HALF   = 5208
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_req,
  input  logic meter_req,
  input  logic rev_req,
  input  logic pwr_down_req,
  input  logic loop_n_i,
  output logic line_en_o,
  output logic mode_a_o,
  output logic mode_b_o,
  output logic polarity_o,
  output logic tone_o
);
  logic      tick, loop_act, meter_next;
  lsc_pins_t pins;

  lsc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  lsc_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .tick_i(tick), .loop_n_i(loop_n_i), .loop_o(loop_act)
  );

  lsc_fsm #(
    .RING_HALF(RING_HALF), .RING_BURST(RING_BURST), .RING_PAUSE(RING_PAUSE),
    .HANG_TICKS(HANG_TICKS), .METER_TICKS(METER_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick_i(tick), .loop_i(loop_act),
    .ring_req_i(ring_req), .meter_req_i(meter_req), .rev_req_i(rev_req),
    .pwr_down_req_i(pwr_down_req), .pins_o(pins), .meter_next_o(meter_next)
  );

  lsc_tone #(.TONE_HALF(TONE_HALF)) u_tone (
    .clk(clk), .rst(rst), .en_i(meter_next), .tone_o(tone_o)
  );

  assign line_en_o  = pins.line_en;
  assign mode_a_o   = pins.mode_a;
  assign mode_b_o   = pins.mode_b;
  assign polarity_o = pins.pol;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker (
  input logic clk,
  input logic rst,
  input logic pwr_down_req,
  input logic line_en_o,
  input logic mode_a_o,
  input logic mode_b_o,
  input logic polarity_o,
  input logic tone_o
);
  logic ringing;
  assign ringing = line_en_o && mode_a_o && !mode_b_o;

  a_r2_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    !line_en_o |-> !(mode_a_o || mode_b_o || polarity_o));

  a_r2_pd_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!line_en_o && pwr_down_req) |-> !line_en_o);

  a_r6_tone_quiet: assert property (@(posedge clk) disable iff (rst)
    !(mode_a_o && mode_b_o) |-> !tone_o);

  a_r3_idle_to_normal: assert property (@(posedge clk) disable iff (rst)
    ($past(line_en_o && !mode_a_o && !mode_b_o) && line_en_o && !mode_a_o && mode_b_o)
      |-> !polarity_o);

  a_r7_burst_starts_direct: assert property (@(posedge clk) disable iff (rst)
    (ringing && !$past(ringing)) |-> !polarity_o);

  a_r9_hold_before_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(ringing) && !ringing && line_en_o) |-> ($past(polarity_o) == $past(polarity_o, 2)));

  a_r8_exit_normal: assert property (@(posedge clk) disable iff (rst)
    ($past(ringing) && !ringing && line_en_o && mode_b_o) |-> (!polarity_o && !mode_a_o));
endmodule

bind line_state_ctrl lsc_checker u_chk (
  .clk(clk), .rst(rst), .pwr_down_req(pwr_down_req),
  .line_en_o(line_en_o), .mode_a_o(mode_a_o), .mode_b_o(mode_b_o),
  .polarity_o(polarity_o), .tone_o(tone_o)
);

// File: tb/tb_line_state_ctrl.sv
module tb_line_state_ctrl;
  localparam int TD = 4, DEB = 2, HALF = 2, BURST = 8, PAUSE = 6, HANG = 5, MET = 4, TONE = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic ring_req = 1'b0, meter_req = 1'b0, rev_req = 1'b0, pwr_down_req = 1'b0, loop_n_i = 1'b1;
  logic line_en_o, mode_a_o, mode_b_o, polarity_o, tone_o;

  line_state_ctrl #(
    .TICK_DIV(TD), .DEB_TICKS(DEB), .RING_HALF(HALF), .RING_BURST(BURST),
    .RING_PAUSE(PAUSE), .HANG_TICKS(HANG), .METER_TICKS(MET), .TONE_HALF(TONE)
  ) dut (
    .clk(clk), .rst(rst), .ring_req(ring_req), .meter_req(meter_req), .rev_req(rev_req),
    .pwr_down_req(pwr_down_req), .loop_n_i(loop_n_i), .line_en_o(line_en_o),
    .mode_a_o(mode_a_o), .mode_b_o(mode_b_o), .polarity_o(polarity_o), .tone_o(tone_o)
  );

  always #4 clk = ~clk;

  wire [3:0] pins = {line_en_o, mode_a_o, mode_b_o, polarity_o};

  int n_cmp = 0, n_bad = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  logic skip_ring = 1'b0;
  logic mon_on = 1'b0;
  logic [3:0] last_pins = 4'b1000;
  bit done = 0;

  task automatic check_pins(string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pins got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(logic [3:0] p, string t);
    exp_q.push_back(p);
    tag_q.push_back(t);
    cur_tag = t;
  endtask

  task automatic drain(string t);
    int k = 0;
    while (exp_q.size() != 0 && k < 600) begin
      @(negedge clk); #1;
      k++;
    end
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s: %0d pin changes missing, got %0d expected 0", t, exp_q.size(), exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic pulse_meter();
    @(negedge clk); meter_req = 1'b1;
    @(negedge clk); meter_req = 1'b0;
  endtask

  task automatic pulse_rev();
    @(negedge clk); rev_req = 1'b1;
    @(negedge clk); rev_req = 1'b0;
  endtask

  // scoreboard monitor: every pin change pops one expected item
  always @(negedge clk) begin
    if (mon_on && pins !== last_pins) begin
      if (skip_ring && pins[2] && !pins[1]) begin
        // ring-mode flips while a trip is being provoked are not itemised
      end else if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s: unexpected pin change got %b expected %b", cur_tag, pins, last_pins);
      end else begin
        check_pins(tag_q.pop_front(), pins, exp_q.pop_front());
      end
      last_pins = pins;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int tr, w, el;
    logic pv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check_pins("R1 reset pins", pins, 4'b1000);
    check_int("R1 reset tone", int'(tone_o), 0);
    mon_on = 1'b1;

    // R3 off-hook in idle -> active normal polarity
    push(4'b1010, "R3");
    loop_n_i = 1'b0;
    drain("R3");

    // R4 polarity flip
    push(4'b1011, "R4");
    pulse_rev();
    drain("R4");

    // R5 metering pulse, R6 tone half period
    push(4'b1111, "R5");
    push(4'b1011, "R5");
    pulse_meter();
    tr = -1; w = -1; pv = tone_o;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tone_o && !pv) tr = i;
      if (!tone_o && pv && tr >= 0 && w < 0) w = i - tr;
      pv = tone_o;
    end
    check_int("R6 tone half period", w, TONE);
    drain("R5");
    @(negedge clk);
    check_int("R6 tone low outside metering", int'(tone_o), 0);

    // R11 on-hook hang time
    push(4'b1000, "R11");
    loop_n_i = 1'b1;
    el = 0;
    repeat (16) begin @(negedge clk); el++; end
    check_pins("R11 still active before hang", pins, 4'b1011);
    while (pins !== 4'b1000 && el < 300) begin @(negedge clk); el++; end
    n_cmp++;
    if (el <= HANG * TD || el >= 300) begin
      n_bad++;
      $display("FAIL R11: idle after %0d cycles expected more than %0d", el, HANG * TD);
    end
    drain("R11");

    // R7 burst flips, R8 hold and pause, then R10 cancel
    ring_req = 1'b1;
    push(4'b1100, "R7");
    push(4'b1101, "R7");
    push(4'b1100, "R7");
    push(4'b1101, "R7");
    push(4'b1010, "R8");
    push(4'b1100, "R8");
    drain("R8");
    ring_req = 1'b0;
    push(4'b1000, "R10");
    drain("R10");

    // R9 ring trip during burst
    ring_req = 1'b1;
    push(4'b1100, "R9");
    drain("R9");
    skip_ring = 1'b1;
    push(4'b1010, "R9");
    loop_n_i = 1'b0;
    drain("R9");
    skip_ring = 1'b0;
    ring_req = 1'b0;
    repeat (10) @(negedge clk);
    check_pins("R9 active normal after trip", pins, 4'b1010);

    // R2 power down ignores loop status and host pulses
    push(4'b0000, "R2");
    pwr_down_req = 1'b1;
    drain("R2");
    loop_n_i = 1'b1;
    repeat (30) @(negedge clk);
    pulse_meter();
    pulse_rev();
    loop_n_i = 1'b0;
    repeat (30) @(negedge clk);
    check_pins("R2 pins stay down", pins, 4'b0000);
    push(4'b1000, "R2");
    push(4'b1010, "R3");
    pwr_down_req = 1'b0;
    drain("R2");

    repeat (20) @(negedge clk);
    check_int("R3 no stray expected items", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule